// File: doc/BRIEF.md
# Grouped-Request DMA Staging FIFO

This block sits between the word buffer of a serial peripheral and a DMA memory port. It holds up to four words and moves a programmed number of words in one of two directions. In transmit, it asks memory for words in groups, stores the returned words, and hands them one at a time to the peripheral. In receive, it takes words from the peripheral and, once a whole group is held, asks memory to accept that group as a write burst.

Each memory request carries the number of words it covers. A transfer is split into groups of four with one final, shorter group for any remainder. Two status outputs report progress separately. `done` is a latched completion flag, cleared by a write-one pulse. `run` stays high while words are still in flight anywhere in the block. In transmit, `done` can be high while `run` is still high, because words may still be waiting for the peripheral.

The memory side uses a request/grant handshake. Read words come back one per `mem_rvalid` beat. Write words leave one per cycle, and memory must take them. The peripheral side uses valid/ready in both directions.

Top module: `pdma_fifo`

## Requirements
- R1: After reset, `done`, `run`, `mem_req`, `mem_wvalid`, `per_tx_valid` and `per_rx_ready` are all 0.
- R2: Each request's `mem_len` (binary word count, 1 to 4) is 4 while at least four words remain to be requested, and is otherwise the remainder. A count of 7 gives lengths 4 then 3, and 6 gives 4 then 2. `mem_req` and `mem_len` hold steady until `mem_gnt`.
- R3: In transmit (`cfg_rx`=0), a read request is raised only when the FIFO has free room for the whole group. The FIFO never holds more than 4 words.
- R4: In transmit, the peripheral receives the words in the order memory returned them, with none lost or repeated.
- R5: In transmit, `done` rises when the last read word arrives from memory, even if the FIFO still holds words. `run` stays 1 until the FIFO is empty.
- R6: In receive (`cfg_rx`=1), exactly the programmed number of peripheral words is accepted. Later offers see `per_rx_ready`=0 and never reach memory.
- R7: In receive, a write request is raised only when the FIFO holds the whole group. Words leave on `mem_wvalid` in arrival order, and `done` rises when the remaining count goes from 1 to 0.
- R8: When the FIFO is full, `per_rx_ready` is 0 and offered words are held off without loss.
- R9: `done` stays 1 until a `done_clr` pulse clears it.
- R10: A start with a count of zero raises `done` on the next cycle, issues no request, and leaves `run` at 0.
- R11: A `cfg_start` pulse while `run` is 1 is ignored.
- R12: `run` is 1 from the cycle after an accepted non-zero start until the last word has moved and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse; loads direction and count |
| cfg_rx | input | 1 | Direction: 1 receive (peripheral to memory), 0 transmit |
| cfg_count | input | CNT_W | Number of words to move |
| done_clr | input | 1 | Write-one pulse that clears `done` |
| mem_req | output | 1 | Memory request, held until granted |
| mem_write | output | 1 | Request kind: 1 write, 0 read |
| mem_len | output | $clog2(GROUP+1) | Words covered by the request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read word beat |
| mem_rdata | input | DW | Read word |
| mem_wvalid | output | 1 | Write word beat (memory must take it) |
| mem_wdata | output | DW | Write word |
| per_tx_valid | output | 1 | Word available for the peripheral |
| per_tx_ready | input | 1 | Peripheral takes the word |
| per_tx_data | output | DW | Word to the peripheral |
| per_rx_valid | input | 1 | Peripheral offers a word |
| per_rx_ready | output | 1 | Block accepts the offered word |
| per_rx_data | input | DW | Word from the peripheral |
| done | output | 1 | Latched completion flag |
| run | output | 1 | Transfer or buffered data still in flight |

## Verification
The hardest states to reach are a full FIFO with a request waiting behind it, and completion raised while data is still buffered. Both need the two sides of the block to run at very different rates. The bench reaches them by stalling one side. It holds `per_tx_ready` low in transmit so the FIFO fills and the second read group has to wait. It also holds back `mem_gnt` in receive so the peripheral meets a full FIFO. It then releases the stall and checks that every word comes out in order. A start pulse sent during the stalled transmit shows that restarts are ignored while data is pending.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   typedef enum logic {
      PDMA_TX = 1'b0,
      PDMA_RX = 1'b1
   } pdma_dir_e;
endpackage

// File: rtl/pdma_ring.sv
module pdma_ring #(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] slot_q [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = slot_q[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slot_q[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/pdma_grouper.sv
module pdma_grouper #(
   parameter int CNT_W = 10,
   parameter int GROUP = 4,
   parameter int DEPTH = 4,
   localparam int LEN_W = $clog2(GROUP + 1),
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   input  logic             dir_rx,
   input  logic [LW-1:0]    level,
   input  logic             gnt,
   input  logic             rvalid,
   output logic             req,
   output logic [LEN_W-1:0] len,
   output logic             bursting,
   output logic             beat,
   output logic             active,
   output logic             finish
);
   logic [CNT_W-1:0] rem_q;
   logic [LEN_W-1:0] left_q, next_len;
   logic             room, issue;
   logic [LW:0]      free_w, lvl_w, need_w;

   assign next_len = (rem_q >= CNT_W'(GROUP)) ? LEN_W'(GROUP) : LEN_W'(rem_q);
   assign lvl_w    = {1'b0, level};
   assign free_w   = (LW+1)'(DEPTH) - lvl_w;
   assign need_w   = (LW+1)'(next_len);
   assign room     = dir_rx ? (lvl_w >= need_w) : (free_w >= need_w);
   assign active   = (rem_q != '0);
   assign bursting = (left_q != '0);
   assign issue    = active && !req && !bursting && room;
   assign beat     = bursting && (dir_rx || rvalid);
   assign finish   = (beat && rem_q == CNT_W'(1)) || (start && count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         left_q <= '0;
         req    <= 1'b0;
         len    <= '0;
      end else if (start) begin
         rem_q  <= count;
         left_q <= '0;
         req    <= 1'b0;
      end else begin
         if (issue) begin
            req <= 1'b1;
            len <= next_len;
         end
         if (req && gnt) begin
            req    <= 1'b0;
            left_q <= len;
         end
         if (beat) begin
            left_q <= left_q - 1'b1;
            rem_q  <= rem_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pdma_flags.sv
module pdma_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic finish,
   input  logic clr,
   input  logic active,
   input  logic empty,
   output logic done,
   output logic run
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done <= 1'b0;
      else if (finish) done <= 1'b1;
      else if (clr)    done <= 1'b0;
   end

   assign run = active || !empty;
endmodule

// File: rtl/pdma_fifo.sv
module pdma_fifo
   import pdma_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   parameter int GROUP = 4,
   parameter int CNT_W = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_start,
   input  logic                       cfg_rx,
   input  logic [CNT_W-1:0]           cfg_count,
   input  logic                       done_clr,
   output logic                       mem_req,
   output logic                       mem_write,
   output logic [$clog2(GROUP+1)-1:0] mem_len,
   input  logic                       mem_gnt,
   input  logic                       mem_rvalid,
   input  logic [DW-1:0]              mem_rdata,
   output logic                       mem_wvalid,
   output logic [DW-1:0]              mem_wdata,
   output logic                       per_tx_valid,
   input  logic                       per_tx_ready,
   output logic [DW-1:0]              per_tx_data,
   input  logic                       per_rx_valid,
   output logic                       per_rx_ready,
   input  logic [DW-1:0]              per_rx_data,
   output logic                       done,
   output logic                       run
);
   localparam int LW = $clog2(DEPTH + 1);

   generate
      if (GROUP < 1 || GROUP > DEPTH) begin : g_bad_group
         $error("pdma_fifo: GROUP must be between 1 and DEPTH");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("pdma_fifo: DEPTH must be at least 2");
      end
      if (CNT_W < $clog2(GROUP + 1)) begin : g_bad_cnt
         $error("pdma_fifo: CNT_W too narrow for GROUP");
      end
   endgenerate

   pdma_dir_e        dir_q;
   logic [CNT_W-1:0] rx_left_q;
   logic             start_ok, is_rx;
   logic             ring_push, ring_pop, ring_full, ring_empty;
   logic [DW-1:0]    ring_wdata, ring_rdata;
   logic [LW-1:0]    ring_level;
   logic             bursting, beat, active, finish;

   assign start_ok = cfg_start && !run;
   assign is_rx    = (dir_q == PDMA_RX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q     <= PDMA_TX;
         rx_left_q <= '0;
      end else if (start_ok) begin
         dir_q     <= cfg_rx ? PDMA_RX : PDMA_TX;
         rx_left_q <= cfg_rx ? cfg_count : '0;
      end else if (per_rx_valid && per_rx_ready) begin
         rx_left_q <= rx_left_q - 1'b1;
      end
   end

   assign per_rx_ready = active && is_rx && (rx_left_q != '0) && !ring_full;
   assign per_tx_valid = !is_rx && !ring_empty;
   assign per_tx_data  = ring_rdata;
   assign mem_wvalid   = is_rx && bursting;
   assign mem_wdata    = ring_rdata;
   assign mem_write    = is_rx;

   assign ring_push  = is_rx ? (per_rx_valid && per_rx_ready) : (bursting && mem_rvalid);
   assign ring_wdata = is_rx ? per_rx_data : mem_rdata;
   assign ring_pop   = is_rx ? mem_wvalid : (per_tx_valid && per_tx_ready);

   pdma_ring #(.DW(DW), .DEPTH(DEPTH)) i_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ring_push),
      .pop   (ring_pop),
      .wdata (ring_wdata),
      .rdata (ring_rdata),
      .level (ring_level),
      .full  (ring_full),
      .empty (ring_empty)
   );

   pdma_grouper #(.CNT_W(CNT_W), .GROUP(GROUP), .DEPTH(DEPTH)) i_grouper (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_ok),
      .count    (cfg_count),
      .dir_rx   (start_ok ? cfg_rx : is_rx),
      .level    (ring_level),
      .gnt      (mem_gnt),
      .rvalid   (mem_rvalid),
      .req      (mem_req),
      .len      (mem_len),
      .bursting (bursting),
      .beat     (beat),
      .active   (active),
      .finish   (finish)
   );

   pdma_flags i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .finish (finish),
      .clr    (done_clr),
      .active (active),
      .empty  (ring_empty),
      .done   (done),
      .run    (run)
   );
endmodule

// File: rtl/pdma_fifo_chk.sv
module pdma_fifo_chk #(
   parameter int DEPTH = 4,
   parameter int GROUP = 4,
   localparam int LW    = $clog2(DEPTH + 1),
   localparam int LEN_W = $clog2(GROUP + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             mem_gnt,
   input logic [LEN_W-1:0] mem_len,
   input logic             mem_wvalid,
   input logic             per_tx_valid,
   input logic             per_rx_ready,
   input logic             done,
   input logic             done_clr,
   input logic             run,
   input logic [LW-1:0]    fifo_level,
   input logic             fifo_empty
);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LW'(DEPTH));
   a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_len != '0 && mem_len <= LEN_W'(GROUP)));
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_len)));
   a_r9_done_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_clr) |=> done);
   a_r5_run_while_data: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_empty |-> run);
   a_r6_rx_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      per_rx_ready |-> run);
   a_r7_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wvalid && per_tx_valid));
endmodule

bind pdma_fifo pdma_fifo_chk #(.DEPTH(DEPTH), .GROUP(GROUP)) i_pdma_fifo_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_req      (mem_req),
   .mem_gnt      (mem_gnt),
   .mem_len      (mem_len),
   .mem_wvalid   (mem_wvalid),
   .per_tx_valid (per_tx_valid),
   .per_rx_ready (per_rx_ready),
   .done         (done),
   .done_clr     (done_clr),
   .run          (run),
   .fifo_level   (ring_level),
   .fifo_empty   (ring_empty)
);

// File: tb/test_pdma_fifo.sv
`timescale 1ns/1ps
module test_pdma_fifo;
   localparam int DW = 16, CNT_W = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_start = 0, cfg_rx = 0, done_clr = 0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic mem_req, mem_write, mem_wvalid, per_tx_valid, per_rx_ready, done, run;
   logic [2:0] mem_len;
   logic mem_gnt = 0, mem_rvalid = 0, per_tx_ready = 0, per_rx_valid = 0;
   logic [DW-1:0] mem_rdata = '0, mem_wdata, per_tx_data, per_rx_data = '0;

   always #2 clk = ~clk;

   pdma_fifo #(.DW(DW), .CNT_W(CNT_W)) i_pdma_fifo (.*);

   int errors = 0, checks = 0;
   bit finished = 0;
   // bench models
   bit tx_go = 1, rx_on = 0, mem_hold = 0, tx_mode = 1, rgap = 0, phase = 0;
   int pend = 0, rd_k = 0, rx_idx = 0, rx_total = 0, rx_took = 0;
   int req_n = 0, wr_n = 0, tx_n = 0;
   int req_log [64];
   int wr_log [64];
   int tx_log [64];

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_gnt = 0; mem_rvalid = 0; pend = 0; per_rx_valid = 0; per_tx_ready = 0; rx_took = 0;
      end else begin
         if (mem_wvalid && wr_n < 64) begin wr_log[wr_n] = int'(mem_wdata); wr_n++; end
         per_tx_ready = tx_go;
         if (per_tx_ready && per_tx_valid && tx_n < 64) begin tx_log[tx_n] = int'(per_tx_data); tx_n++; end
         if (mem_gnt) begin
            if (req_n < 64) req_log[req_n] = int'(mem_len);
            req_n++;
            if (tx_mode) pend = int'(mem_len);
         end
         mem_gnt = mem_req && !mem_hold;
         phase = !phase;
         if (pend > 0 && !(rgap && phase)) begin
            mem_rvalid = 1; mem_rdata = DW'(16'hA000 + rd_k); rd_k++; pend--;
         end else mem_rvalid = 0;
         if (rx_took != 0) rx_idx++;
         per_rx_valid = rx_on && (rx_idx < rx_total);
         per_rx_data  = DW'(16'h5000 + rx_idx);
         rx_took = (per_rx_valid && per_rx_ready) ? 1 : 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_logs();
      req_n = 0; wr_n = 0; tx_n = 0; rd_k = 0; rx_idx = 0; rx_took = 0; pend = 0;
   endtask

   task automatic start(input bit rx, input int cnt);
      @(negedge clk);
      cfg_rx = rx; cfg_count = CNT_W'(cnt); cfg_start = 1;
      @(negedge clk);
      cfg_start = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); done_clr = 1;
      @(negedge clk); done_clr = 0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (!(done && !run) && n < 2000) begin @(negedge clk); n++; end
      chk(n < 2000, {tag, " reached completion"}, n, 0);
   endtask

   task automatic chk_groups(input int cnt, input string tag);
      int r = cnt, k = 0;
      while (r > 0) begin
         int g = (r >= 4) ? 4 : r;
         chk(k < req_n && req_log[k] == g, tag, (k < req_n) ? req_log[k] : -1, g);
         r -= g; k++;
      end
      chk(req_n == k, {tag, " request count"}, req_n, k);
   endtask

   task automatic t_reset();
      chk(done == 0 && run == 0, "R1 done/run after reset", {done, run}, 0);
      chk(mem_req == 0 && mem_wvalid == 0, "R1 memory side idle", {mem_req, mem_wvalid}, 0);
      chk(per_tx_valid == 0 && per_rx_ready == 0, "R1 peripheral side idle", {per_tx_valid, per_rx_ready}, 0);
   endtask

   task automatic t_tx_basic();
      clear_logs(); tx_mode = 1; tx_go = 1; rgap = 1;
      start(0, 7);
      chk(run == 1, "R12 run high after start", run, 1);
      wait_idle("R5 tx 7");
      repeat (4) @(negedge clk);
      chk_groups(7, "R2 tx groups 4,3");
      chk(tx_n == 7, "R4 tx word count", tx_n, 7);
      for (int i = 0; i < 7; i++)
         chk(tx_log[i] == 16'hA000 + i, "R4 tx order", tx_log[i], 16'hA000 + i);
      chk(run == 0, "R12 run low after drain", run, 0);
      rgap = 0;
      pulse_clr();
   endtask

   task automatic t_tx_stall();
      clear_logs(); tx_mode = 1; tx_go = 0;
      start(0, 8);
      repeat (40) @(negedge clk);
      chk(req_n == 1, "R3 second group waits for room", req_n, 1);
      chk(done == 0 && run == 1, "R12 stalled tx still running", {done, run}, 1);
      tx_go = 1;
      wait_idle("R3 tx 8");
      chk_groups(8, "R2 tx groups 4,4");
      chk(tx_n == 8 && tx_log[7] == 16'hA007, "R4 tx last word after stall", tx_log[7], 16'hA007);
      pulse_clr();
   endtask

   task automatic t_done_pending();
      clear_logs(); tx_mode = 1; tx_go = 0;
      start(0, 4);
      repeat (30) @(negedge clk);
      chk(done == 1 && run == 1, "R5 done while FIFO holds words", {done, run}, 3);
      tx_go = 1;
      repeat (10) @(negedge clk);
      chk(run == 0, "R5 run drops after drain", run, 0);
      repeat (20) @(negedge clk);
      chk(done == 1, "R9 done stays latched", done, 1);
      pulse_clr();
      chk(done == 0, "R9 done cleared by write-one", done, 0);
   endtask

   task automatic t_rx_basic();
      clear_logs(); tx_mode = 0; rx_total = 9;
      start(1, 6);
      rx_on = 1;
      wait_idle("R7 rx 6");
      repeat (10) @(negedge clk);
      chk(wr_n == 6, "R6 exactly count words written", wr_n, 6);
      chk(rx_idx == 6 && per_rx_ready == 0, "R6 extra offers held off", rx_idx, 6);
      for (int i = 0; i < 6; i++)
         chk(wr_log[i] == 16'h5000 + i, "R7 rx write order", wr_log[i], 16'h5000 + i);
      chk_groups(6, "R2 rx groups 4,2");
      rx_on = 0;
      pulse_clr();
   endtask

   task automatic t_rx_hold();
      clear_logs(); tx_mode = 0; rx_total = 8; mem_hold = 1;
      start(1, 8);
      rx_on = 1;
      repeat (30) @(negedge clk);
      chk(rx_idx == 4, "R8 accepted words while memory stalled", rx_idx, 4);
      chk(per_rx_ready == 0 && per_rx_valid == 1, "R8 full FIFO holds off peripheral", per_rx_ready, 0);
      chk(wr_n == 0, "R7 no writes before grant", wr_n, 0);
      mem_hold = 0;
      wait_idle("R8 rx 8");
      chk(wr_n == 8, "R8 no words lost", wr_n, 8);
      for (int i = 0; i < 8; i++)
         chk(wr_log[i] == 16'h5000 + i, "R8 order kept through hold-off", wr_log[i], 16'h5000 + i);
      rx_on = 0;
      pulse_clr();
   endtask

   task automatic t_zero();
      clear_logs(); tx_mode = 1;
      start(0, 0);
      chk(done == 1, "R10 zero count sets done next cycle", done, 1);
      chk(run == 0, "R10 zero count leaves run low", run, 0);
      repeat (10) @(negedge clk);
      chk(req_n == 0 && mem_req == 0, "R10 no request for zero count", req_n, 0);
      pulse_clr();
   endtask

   task automatic t_restart_ignored();
      clear_logs(); tx_mode = 1; tx_go = 0;
      start(0, 5);
      repeat (20) @(negedge clk);
      start(1, 2);
      chk(mem_write == 0, "R11 direction unchanged by ignored start", mem_write, 0);
      tx_go = 1;
      wait_idle("R11 tx 5");
      chk_groups(5, "R11 groups follow first start");
      chk(tx_n == 5, "R11 word count of first start", tx_n, 5);
      pulse_clr();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tx_basic();
      t_tx_stall();
      t_done_pending();
      t_rx_basic();
      t_rx_hold();
      t_zero();
      t_restart_ignored();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule